// File: doc/BRIEF.md
# Open-Page Request Sequencer

This block sits between four requesting ports and a single SDRAM-style command bus. Each port presents a bank, row and column address and a write flag. The block accepts at most one request per cycle into a two-entry holding buffer. Every cycle it emits at most one command: row activate, read, write or precharge. For every bank it remembers whether a row is open and which one. This lets it serve a request that hits an already-open row while the activate for another bank's request is still counting down.

The choice between the two held requests follows fixed port priority first. If the higher-priority request cannot issue its next command in this cycle, and the other request targets a different bank, the other request goes ahead. When both requests target the same bank they are served one after the other in priority order. Each access moves a four-beat burst. Access columns are therefore burst-aligned, and accesses are spaced by the burst length.

Top module: `page_seq`

## Requirements
- R1: When fewer than two requests are held, the lowest-numbered port with `req_i` high is granted in that cycle (one grant per cycle, port 0 highest). The request is captured at that clock edge.
- R2: At most two requests are held. While both entries are occupied, no grant is given. A slot becomes free for a grant in the cycle after its access command issues.
- R3: A request to a bank with no open row first causes an activate carrying its row. A request to a bank whose open row differs first causes a precharge of that bank, then an activate. Reads and writes issue only to the open row.
- R4: An access to a row issues no earlier than `ACT_DLY` cycles after the activate of that row (default 2).
- R5: Accesses are `BURST`-beat bursts (default 4). The column on `cmd_col_o` has its low log2(`BURST`) bits cleared, and two accesses are at least `BURST` cycles apart.
- R6: The held request from the lower-numbered port issues when its next command is ready. Otherwise the other held request, if it targets a different bank and its command is ready, issues in that cycle. Example: an activate for a closed row on port 2 is followed by a hit on port 3 in the next cycle, then by the port 2 access.
- R7: When both held requests target the same bank, the lower-priority one issues no command until the higher-priority one has issued its access.
- R8: `cmd_op_o` encodes 0 = activate, 1 = read, 2 = write, 3 = precharge. The write flag selects write over read. `cmd_port_o` names the port whose request the command serves.
- R9: After reset, all banks are closed and the buffer is empty: no command is issued, and the first request to any bank starts with an activate.
- R10: Two held requests from the same port rank by age, the older being treated as higher priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NPORT | Per-port request, held until granted |
| req_bank_i | input | NPORT x log2(NBANK) | Per-port target bank |
| req_row_i | input | NPORT x ROW_W | Per-port target row |
| req_col_i | input | NPORT x COL_W | Per-port target column |
| req_wr_i | input | NPORT | Per-port write flag (1 = write) |
| gnt_o | output | NPORT | One-hot grant, request taken at this edge |
| cmd_valid_o | output | 1 | A command is issued in this cycle |
| cmd_op_o | output | 2 | Command code, see R8 |
| cmd_bank_o | output | log2(NBANK) | Command bank |
| cmd_row_o | output | ROW_W | Row of the served request |
| cmd_col_o | output | COL_W | Burst-aligned column of the served request |
| cmd_port_o | output | log2(NPORT) | Port served by the command |

## Verification
The bench builds the block with four ports, four banks, `ACT_DLY` = 2 and `BURST` = 4. It narrows rows to 4 bits and columns to 6 bits. Random traffic is also confined to four row values, so page hits, row conflicts and same-bank pairs occur often. The two-cycle activate delay opens a window in which a later hit can overtake. The four-cycle burst spacing makes ready activates and precharges interleave with waiting accesses, and leaves the buffer full long enough for grants to stall.

// File: rtl/page_seq_pkg.sv
package page_seq_pkg;
    typedef enum logic [1:0] {
        OP_ACT = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2,
        OP_PRE = 2'd3
    } seq_op_e;
endpackage

// File: rtl/page_seq_banks.sv
module page_seq_banks
    import page_seq_pkg::*;
#(
    parameter int NBANK   = 4,
    parameter int ROW_W   = 13,
    parameter int ACT_DLY = 2,
    localparam int BANK_W = $clog2(NBANK),
    localparam int TMR_W  = $clog2(ACT_DLY + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_fire_i,
    input  seq_op_e                     cmd_op_i,
    input  logic [BANK_W-1:0]           cmd_bank_i,
    input  logic [ROW_W-1:0]            cmd_row_i,
    output logic [NBANK-1:0]            open_o,
    output logic [NBANK-1:0][ROW_W-1:0] row_o,
    output logic [NBANK-1:0]            ready_o
);
    timeunit 1ns;
    timeprecision 1ps;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        typedef struct packed {
            logic             open;
            logic [ROW_W-1:0] row;
            logic [TMR_W-1:0] tmr;
        } bank_t;

        bank_t st_d, st_q;
        logic  hit;

        assign hit = cmd_fire_i && (cmd_bank_i == BANK_W'(b));

        always_comb begin
            st_d = st_q;
            if (st_q.tmr != '0) st_d.tmr = st_q.tmr - 1'b1;
            if (hit && cmd_op_i == OP_ACT) begin
                st_d.open = 1'b1;
                st_d.row  = cmd_row_i;
                st_d.tmr  = TMR_W'(ACT_DLY - 1);
            end else if (hit && cmd_op_i == OP_PRE) begin
                st_d.open = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign open_o[b]  = st_q.open;
        assign row_o[b]   = st_q.row;
        assign ready_o[b] = (st_q.tmr == '0);

        // R3: an activate only targets a closed bank, a precharge only an open one
        a_r3_act_on_closed: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && cmd_op_i == OP_ACT) |-> !st_q.open);
        a_r3_pre_on_open: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && cmd_op_i == OP_PRE) |-> st_q.open);
    end
endmodule

// File: rtl/page_seq_pick.sv
module page_seq_pick
    import page_seq_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int NBANK = 4,
    parameter int ROW_W = 13,
    localparam int PW     = $clog2(NPORT),
    localparam int BANK_W = $clog2(NBANK)
) (
    input  logic [1:0]                  slot_vld_i,
    input  logic [1:0][PW-1:0]          slot_port_i,
    input  logic [1:0][BANK_W-1:0]      slot_bank_i,
    input  logic [1:0][ROW_W-1:0]       slot_row_i,
    input  logic [1:0]                  slot_wr_i,
    input  logic [NBANK-1:0]            open_i,
    input  logic [NBANK-1:0][ROW_W-1:0] row_i,
    input  logic [NBANK-1:0]            ready_i,
    input  logic                        bus_free_i,
    output logic                        fire_o,
    output logic                        sel_o,
    output seq_op_e                     op_o
);
    timeunit 1ns;
    timeprecision 1ps;

    seq_op_e    op_s [2];
    logic [1:0] rdy;
    logic       pri;
    logic       sec;

    always_comb begin
        for (int s = 0; s < 2; s++) begin
            if (!open_i[slot_bank_i[s]]) begin
                op_s[s] = OP_ACT;
                rdy[s]  = 1'b1;
            end else if (row_i[slot_bank_i[s]] != slot_row_i[s]) begin
                op_s[s] = OP_PRE;
                rdy[s]  = 1'b1;
            end else begin
                op_s[s] = slot_wr_i[s] ? OP_WR : OP_RD;
                rdy[s]  = ready_i[slot_bank_i[s]] && bus_free_i;
            end
        end
        // slot 0 is older; it wins ties on port number
        pri    = slot_vld_i[1] && (slot_port_i[1] < slot_port_i[0]);
        sec    = !pri;
        fire_o = 1'b0;
        sel_o  = pri;
        if (slot_vld_i[pri] && rdy[pri]) begin
            fire_o = 1'b1;
        end else if (slot_vld_i[sec] && slot_vld_i[pri] &&
                     (slot_bank_i[0] != slot_bank_i[1]) && rdy[sec]) begin
            fire_o = 1'b1;
            sel_o  = sec;
        end
        op_o = op_s[sel_o];
    end
endmodule

// File: rtl/page_seq.sv
module page_seq
    import page_seq_pkg::*;
#(
    parameter int NPORT   = 4,
    parameter int NBANK   = 4,
    parameter int ROW_W   = 13,
    parameter int COL_W   = 10,
    parameter int ACT_DLY = 2,
    parameter int BURST   = 4,
    localparam int PW     = $clog2(NPORT),
    localparam int BANK_W = $clog2(NBANK)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPORT-1:0]             req_i,
    input  logic [NPORT-1:0][BANK_W-1:0] req_bank_i,
    input  logic [NPORT-1:0][ROW_W-1:0]  req_row_i,
    input  logic [NPORT-1:0][COL_W-1:0]  req_col_i,
    input  logic [NPORT-1:0]             req_wr_i,
    output logic [NPORT-1:0]             gnt_o,
    output logic                         cmd_valid_o,
    output logic [1:0]                   cmd_op_o,
    output logic [BANK_W-1:0]            cmd_bank_o,
    output logic [ROW_W-1:0]             cmd_row_o,
    output logic [COL_W-1:0]             cmd_col_o,
    output logic [PW-1:0]                cmd_port_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int BUS_W = $clog2(BURST + 1);
    localparam logic [COL_W-1:0] BEAT_MASK = COL_W'(BURST - 1);

    typedef struct packed {
        logic              vld;
        logic [PW-1:0]     port;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              wr;
    } ent_t;

    typedef struct packed {
        ent_t [1:0]       slot;
        logic [BUS_W-1:0] bus;
    } state_t;

    state_t st_d, st_q;
    ent_t   new_ent;
    ent_t   sel_ent;
    logic   pick_fire;
    logic   pick_sel;
    seq_op_e pick_op;
    logic   is_acc;

    logic [1:0]              s_vld;
    logic [1:0][PW-1:0]      s_port;
    logic [1:0][BANK_W-1:0]  s_bank;
    logic [1:0][ROW_W-1:0]   s_row;
    logic [1:0]              s_wr;
    logic [NBANK-1:0]            bk_open;
    logic [NBANK-1:0][ROW_W-1:0] bk_row;
    logic [NBANK-1:0]            bk_ready;

    always_comb begin
        for (int s = 0; s < 2; s++) begin
            s_vld[s]  = st_q.slot[s].vld;
            s_port[s] = st_q.slot[s].port;
            s_bank[s] = st_q.slot[s].bank;
            s_row[s]  = st_q.slot[s].row;
            s_wr[s]   = st_q.slot[s].wr;
        end
    end

    page_seq_pick #(.NPORT(NPORT), .NBANK(NBANK), .ROW_W(ROW_W)) u_pick (
        .slot_vld_i (s_vld),
        .slot_port_i(s_port),
        .slot_bank_i(s_bank),
        .slot_row_i (s_row),
        .slot_wr_i  (s_wr),
        .open_i     (bk_open),
        .row_i      (bk_row),
        .ready_i    (bk_ready),
        .bus_free_i (st_q.bus == '0),
        .fire_o     (pick_fire),
        .sel_o      (pick_sel),
        .op_o       (pick_op)
    );

    assign sel_ent = st_q.slot[pick_sel];
    assign is_acc  = pick_fire && (pick_op == OP_RD || pick_op == OP_WR);

    page_seq_banks #(.NBANK(NBANK), .ROW_W(ROW_W), .ACT_DLY(ACT_DLY)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_fire_i(pick_fire),
        .cmd_op_i  (pick_op),
        .cmd_bank_i(sel_ent.bank),
        .cmd_row_i (sel_ent.row),
        .open_o    (bk_open),
        .row_o     (bk_row),
        .ready_o   (bk_ready)
    );

    // grant: lowest-numbered requester while a slot is free
    always_comb begin
        gnt_o   = '0;
        new_ent = '0;
        if (!(st_q.slot[0].vld && st_q.slot[1].vld)) begin
            for (int p = 0; p < NPORT; p++) begin
                if (req_i[p] && !new_ent.vld) begin
                    gnt_o[p]     = 1'b1;
                    new_ent.vld  = 1'b1;
                    new_ent.port = PW'(p);
                    new_ent.bank = req_bank_i[p];
                    new_ent.row  = req_row_i[p];
                    new_ent.col  = req_col_i[p];
                    new_ent.wr   = req_wr_i[p];
                end
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (st_q.bus != '0) st_d.bus = st_q.bus - 1'b1;
        if (is_acc) begin
            st_d.bus = BUS_W'(BURST - 1);
            if (!pick_sel) st_d.slot[0] = st_q.slot[1];
            st_d.slot[1].vld = 1'b0;
        end
        if (new_ent.vld) begin
            if (!st_d.slot[0].vld) st_d.slot[0] = new_ent;
            else                   st_d.slot[1] = new_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_valid_o = pick_fire;
    assign cmd_op_o    = pick_fire ? pick_op : 2'd0;
    assign cmd_bank_o  = pick_fire ? sel_ent.bank : '0;
    assign cmd_row_o   = pick_fire ? sel_ent.row : '0;
    assign cmd_col_o   = pick_fire ? (sel_ent.col & ~BEAT_MASK) : '0;
    assign cmd_port_o  = pick_fire ? sel_ent.port : '0;

    // R3: reads and writes only reach the row the bank table holds open
    a_r3_access_open_row: assert property (@(posedge clk) disable iff (!rst_n)
        is_acc |-> (bk_open[cmd_bank_o] && bk_row[cmd_bank_o] == cmd_row_o));

    if (BURST > 1) begin : g_burst_chk
        // R5: no access in the cycle right after an access
        a_r5_burst_gap: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid_o && (cmd_op_o == 2'd1 || cmd_op_o == 2'd2)) |=>
            !(cmd_valid_o && (cmd_op_o == 2'd1 || cmd_op_o == 2'd2)));
    end

    if (ACT_DLY > 1) begin : g_act_chk
        // R4: an access never directly follows the activate of its own bank
        a_r4_act_to_access: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid_o && (cmd_op_o == 2'd1 || cmd_op_o == 2'd2)) |->
            !($past(cmd_valid_o) && $past(cmd_op_o) == 2'd0 &&
              $past(cmd_bank_o) == cmd_bank_o));
    end
endmodule

// File: tb/page_seq_bench.sv
module page_seq_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NP = 4, NB = 4, RW = 4, CW = 6, AD = 2, BL = 4;
    localparam int PW = $clog2(NP), BW = $clog2(NB);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [NP-1:0]         req = '0;
    logic [NP-1:0][BW-1:0] rb = '0;
    logic [NP-1:0][RW-1:0] rr = '0;
    logic [NP-1:0][CW-1:0] rc = '0;
    logic [NP-1:0]         rwr = '0;
    logic [NP-1:0]         gnt_o;
    logic                  cmd_valid_o;
    logic [1:0]            cmd_op_o;
    logic [BW-1:0]         cmd_bank_o;
    logic [RW-1:0]         cmd_row_o;
    logic [CW-1:0]         cmd_col_o;
    logic [PW-1:0]         cmd_port_o;

    page_seq #(.NPORT(NP), .NBANK(NB), .ROW_W(RW), .COL_W(CW),
               .ACT_DLY(AD), .BURST(BL)) u_page_seq (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_bank_i(rb),
        .req_row_i(rr), .req_col_i(rc), .req_wr_i(rwr), .gnt_o(gnt_o),
        .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_bank_o(cmd_bank_o),
        .cmd_row_o(cmd_row_o), .cmd_col_o(cmd_col_o), .cmd_port_o(cmd_port_o)
    );

    typedef struct { int port; int bank; int row; int col; int wr; } ent_s;
    typedef struct { int cyc; int op; int bank; int row; int col; int port; } log_s;
    typedef struct { int cyc; int port; } glog_s;

    ent_s  mq[$];
    log_s  lg[$];
    glog_s gl[$];
    int m_open[NB], m_row[NB], m_tmr[NB];
    int m_bus = 0;
    int n_chk = 0, n_bad = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic need(input ent_s e, output int op, output bit rdy);
        if (m_open[e.bank] == 0) begin op = 0; rdy = 1; end
        else if (m_row[e.bank] != e.row) begin op = 3; rdy = 1; end
        else begin
            op  = e.wr ? 2 : 1;
            rdy = (m_tmr[e.bank] == 0) && (m_bus == 0);
        end
    endtask

    task automatic step();
        int eg, ei, pri, sec, op_a[2];
        bit rd_a[2];
        logic [NP-1:0] egv;
        #1;
        eg = -1;
        if (mq.size() < 2)
            for (int p = 0; p < NP; p++) if (req[p] && eg < 0) eg = p;
        egv = (eg >= 0) ? NP'(1 << eg) : '0;
        for (int i = 0; i < mq.size(); i++) need(mq[i], op_a[i], rd_a[i]);
        ei = -1;
        if (mq.size() > 0) begin
            pri = (mq.size() == 2 && mq[1].port < mq[0].port) ? 1 : 0;
            sec = 1 - pri;
            if (rd_a[pri]) ei = pri;
            else if (mq.size() == 2 && mq[0].bank != mq[1].bank && rd_a[sec]) ei = sec;
        end
        chk(gnt_o === egv, "R1", "grant vector", int'(gnt_o), int'(egv));
        chk(cmd_valid_o === (ei >= 0), "R6", "command valid", int'(cmd_valid_o), int'(ei >= 0));
        if (ei >= 0 && cmd_valid_o) begin
            chk(int'(cmd_op_o) == op_a[ei], "R8", "command code", int'(cmd_op_o), op_a[ei]);
            chk(int'(cmd_bank_o) == mq[ei].bank, "R6", "command bank", int'(cmd_bank_o), mq[ei].bank);
            chk(int'(cmd_port_o) == mq[ei].port, "R6", "command port", int'(cmd_port_o), mq[ei].port);
            chk(int'(cmd_row_o) == mq[ei].row, "R3", "command row", int'(cmd_row_o), mq[ei].row);
            chk(int'(cmd_col_o) == (mq[ei].col & ~(BL - 1)), "R5", "burst column",
                int'(cmd_col_o), mq[ei].col & ~(BL - 1));
        end
        if (cmd_valid_o)
            lg.push_back('{cyc, int'(cmd_op_o), int'(cmd_bank_o), int'(cmd_row_o),
                           int'(cmd_col_o), int'(cmd_port_o)});
        for (int p = 0; p < NP; p++) if (gnt_o[p]) gl.push_back('{cyc, p});
        // model advances over the coming edge
        for (int b = 0; b < NB; b++) if (m_tmr[b] > 0) m_tmr[b]--;
        if (m_bus > 0) m_bus--;
        if (ei >= 0) begin
            case (op_a[ei])
                0: begin m_open[mq[ei].bank] = 1; m_row[mq[ei].bank] = mq[ei].row;
                         m_tmr[mq[ei].bank] = AD - 1; end
                3: m_open[mq[ei].bank] = 0;
                default: begin m_bus = BL - 1; mq.delete(ei); end
            endcase
        end
        if (eg >= 0) mq.push_back('{eg, int'(rb[eg]), int'(rr[eg]), int'(rc[eg]), int'(rwr[eg])});
        @(posedge clk);
        @(negedge clk);
        if (eg >= 0) req[eg] = 1'b0;
        cyc++;
    endtask

    task automatic issue(input int p, input int bank, input int row, input int col, input int wr);
        req[p] = 1'b1; rb[p] = BW'(bank); rr[p] = RW'(row); rc[p] = CW'(col); rwr[p] = wr[0];
    endtask

    task automatic drain();
        for (int k = 0; k < 200 && (mq.size() > 0 || req != '0); k++) step();
        step();
    endtask

    function automatic int find_cmd(input int p, input int op, input int from);
        foreach (lg[i])
            if (lg[i].cyc >= from && lg[i].port == p && (op < 0 || lg[i].op == op)) return i;
        return -1;
    endfunction

    function automatic int find_gnt(input int p, input int from);
        foreach (gl[i]) if (gl[i].cyc >= from && gl[i].port == p) return gl[i].cyc;
        return -1;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL R6 watchdog: actual cycle %0d expected completion", cyc);
        summary();
        $finish;
    end

    initial begin
        int t, ia, ib, ic, i0, i1, ga, gb, gc;
        for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_row[b] = 0; m_tmr[b] = 0; end
        repeat (3) @(negedge clk);
        #1;
        chk(cmd_valid_o === 1'b0, "R9", "command during reset", int'(cmd_valid_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step();

        // R9, R5: first request after reset activates, column is burst-aligned
        t = cyc; issue(3, 1, 5, 6, 0); drain();
        ia = find_cmd(3, 0, t); ib = find_cmd(3, 1, t);
        chk(ia >= 0, "R9", "activate after reset found", ia, 0);
        chk(ib >= 0 && lg[ib].col == 4, "R5", "aligned column", (ib >= 0) ? lg[ib].col : -1, 4);

        // R6, R4, R5: closed row on port 2, open-row hit on port 3
        t = cyc; issue(2, 2, 7, 0, 0); issue(3, 1, 5, 8, 0); drain();
        ia = find_cmd(2, 0, t); ib = find_cmd(3, 1, t); ic = find_cmd(2, 1, t);
        chk(ia >= 0 && ib >= 0 && ic >= 0 && lg[ib].cyc == lg[ia].cyc + 1 && lg[ic].cyc > lg[ib].cyc,
            "R6", "activate, hit, then delayed access", (ib >= 0) ? lg[ib].cyc : -1, (ia >= 0) ? lg[ia].cyc + 1 : -1);
        chk(ia >= 0 && ic >= 0 && lg[ic].cyc - lg[ia].cyc >= AD, "R4", "activate to access distance",
            (ia >= 0 && ic >= 0) ? lg[ic].cyc - lg[ia].cyc : -1, AD);
        chk(ib >= 0 && ic >= 0 && lg[ic].cyc - lg[ib].cyc == BL, "R5", "access spacing",
            (ib >= 0 && ic >= 0) ? lg[ic].cyc - lg[ib].cyc : -1, BL);

        // R3, R8: row conflict write -> precharge, activate, write
        t = cyc; issue(1, 1, 9, 3, 1); drain();
        ia = find_cmd(1, 3, t); ib = find_cmd(1, 0, t); ic = find_cmd(1, 2, t);
        chk(ia >= 0 && ib >= 0 && ia < ib, "R3", "precharge before activate", ia, ib);
        chk(ib >= 0 && lg[ib].row == 9, "R3", "activate row", (ib >= 0) ? lg[ib].row : -1, 9);
        chk(ic > ib && ib >= 0, "R8", "write code follows activate", ic, ib + 1);

        // R7: same bank, strict priority order
        t = cyc; issue(0, 3, 2, 0, 0); issue(1, 3, 4, 0, 1); drain();
        i0 = find_cmd(0, 1, t); i1 = find_cmd(1, -1, t);
        chk(i0 >= 0 && i1 >= 0 && lg[i1].cyc > lg[i0].cyc, "R7", "lower port waits for bank",
            (i1 >= 0) ? lg[i1].cyc : -1, (i0 >= 0) ? lg[i0].cyc + 1 : -1);

        // R10: two entries from one port, older served first
        t = cyc; issue(2, 0, 1, 0, 0);
        for (int k = 0; k < 10 && req[2]; k++) step();
        issue(2, 2, 7, 0, 0); drain();
        i0 = find_cmd(2, -1, t);
        chk(i0 >= 0 && lg[i0].bank == 0, "R10", "older entry issues first", (i0 >= 0) ? lg[i0].bank : -1, 0);

        // R2, R1: buffer full blocks further grants
        t = cyc; issue(0, 0, 3, 0, 0); issue(1, 1, 2, 0, 0); issue(3, 2, 7, 0, 0); drain();
        ga = find_gnt(0, t); gb = find_gnt(1, t); gc = find_gnt(3, t);
        i0 = -1;
        foreach (lg[i]) if (i0 < 0 && lg[i].cyc >= t && (lg[i].op == 1 || lg[i].op == 2)) i0 = i;
        chk(ga == t && gb == t + 1, "R1", "priority grant order", gb, t + 1);
        chk(i0 >= 0 && gc == lg[i0].cyc + 1, "R2", "grant waits for a freed slot",
            gc, (i0 >= 0) ? lg[i0].cyc + 1 : -1);

        // random traffic with narrow rows, compared every cycle
        for (int k = 0; k < 3000; k++) begin
            for (int p = 0; p < NP; p++)
                if (!req[p] && $urandom_range(0, 9) < 3)
                    issue(p, $urandom_range(0, NB - 1), $urandom_range(0, 3),
                          $urandom_range(0, (1 << CW) - 1), $urandom_range(0, 1));
            step();
        end
        drain();
        summary();
        $finish;
    end
endmodule